// File: doc/BRIEF.md
# Reorder Buffer with Embedded Operand Storage

This block is a small circular reorder buffer whose slots also serve as the waiting stations for instructions. Each dispatched instruction carries an opcode, a destination architectural register and two source operands. A source arrives either as a ready value or as the tag of the instruction that will produce it. The tag of every instruction is simply the index of the slot it occupies, which is the allocation pointer at the moment it was accepted.

Each cycle the block accepts at most one dispatch, at most one completion broadcast (tag, result, exception flag) and retires at most one instruction. A completion writes the result into the producing slot and, by associative tag comparison, wakes every waiting source that named that tag, copying the data into it. A combinational issue port presents the oldest slot whose sources are both present and that has not yet issued; the execution side accepts it with a request strobe. The oldest slot retires once its result is present. A clean result goes out on a register write port. A result with its exception flag set instead raises a trap, empties the buffer and moves the allocation pointer back onto the oldest pointer.

Top module: `rob_data_buf`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `iss_valid`, `cm_we` and `trap` are 0.
- R2: Each accepted dispatch receives as its tag the current allocation index. Tags advance by one per dispatch modulo DEPTH and wrap around.
- R3: Once DEPTH instructions are held, `disp_ready` is 0 and a dispatch offered then is ignored. It takes no slot and produces no later issue or retirement.
- R4: A slot is offered for issue only when both of its sources are present. The issue port then shows the slot's tag, opcode and both operand values.
- R5: Among eligible slots, the one issued is the oldest, with age counted from the oldest pointer. A slot accepted with `iss_req` is never offered again.
- R6: A completion for tag T sets presence and copies the data into every waiting source in the buffer whose tag is T. Such a source becomes issuable in the next cycle.
- R7: A dispatch whose busy source names the tag being completed in the same cycle stores that source as present, with the broadcast data.
- R8: Retirement is in program order. The oldest slot drives `cm_we`=1 with its `rd` and result in the cycle after its result arrives, and younger completed slots wait behind it.
- R9: When the oldest slot has a result with its exception flag set, `trap` is 1 and `cm_we` is 0 for that cycle. Afterwards every slot is gone, nothing issues or retires, and the next dispatch gets the tag of the trapping slot.
- R10: A completion whose tag names no held slot changes no slot and wakes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OPW | Opcode of the dispatched instruction |
| disp_rd | input | AW | Destination architectural register |
| disp_s1_rdy | input | 1 | Source 1 carries a value (1) or a producer tag (0) |
| disp_s1_tag | input | TW | Producer tag of source 1 |
| disp_s1_val | input | DW | Value of source 1 |
| disp_s2_rdy | input | 1 | Source 2 carries a value (1) or a producer tag (0) |
| disp_s2_tag | input | TW | Producer tag of source 2 |
| disp_s2_val | input | DW | Value of source 2 |
| disp_ready | output | 1 | A dispatch this cycle is accepted |
| disp_tag | output | TW | Tag that a dispatch this cycle receives |
| cmp_valid | input | 1 | Completion broadcast valid |
| cmp_tag | input | TW | Tag of the completing instruction |
| cmp_data | input | DW | Result value |
| cmp_exc | input | 1 | Exception flag of the result |
| iss_req | input | 1 | Execution side accepts the offered instruction |
| iss_valid | output | 1 | An instruction is offered for issue |
| iss_tag | output | TW | Tag of the offered instruction |
| iss_op | output | OPW | Opcode of the offered instruction |
| iss_a | output | DW | Operand 1 of the offered instruction |
| iss_b | output | DW | Operand 2 of the offered instruction |
| cm_we | output | 1 | Register file write from retirement |
| cm_rd | output | AW | Register written at retirement |
| cm_data | output | DW | Value written at retirement |
| trap | output | 1 | Oldest instruction retires with an exception; buffer is flushed |

## Verification
A slot whose presence bit or captured value is wrong shows up on the issue port within one cycle of the broadcast. Either the dependent is not offered, or it is offered with a stale operand. A drifted allocation or oldest pointer is seen at once on `disp_tag`, or as a wrong register or value on the retirement port when that slot reaches the head. An incomplete flush leaves a stale slot that appears on the issue or retirement port in the cycle after `trap`.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Default geometry of the buffer
    localparam int ROB_DEPTH_DEF = 4;
    localparam int ROB_DW_DEF    = 8;
    localparam int ROB_OPW_DEF   = 4;
    localparam int ROB_AW_DEF    = 3;

    // What the head slot does this cycle
    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_RETIRE = 2'd1,
        CM_TRAP   = 2'd2
    } cm_act_e;

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int DEPTH = 4,
    parameter int TW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [TW-1:0] head;
        logic [TW-1:0] tail;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d.tail = ptr_q.head;
            ptr_d.cnt  = '0;
        end else begin
            if (push) ptr_d.tail = ptr_q.tail + 1'b1;
            if (pop)  ptr_d.head = ptr_q.head + 1'b1;
            ptr_d.cnt = ptr_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head  = ptr_q.head;
    assign tail  = ptr_q.tail;
    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.cnt <= CW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R2
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> (tail == TW'($past(tail) + 1'b1)));

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int DEPTH = 4,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] elig,
    input  logic [TW-1:0]    base,
    output logic             found,
    output logic [TW-1:0]    idx
);

    // Scan from youngest to oldest so the oldest eligible slot wins
    always_comb begin
        logic [TW-1:0] j;
        found = 1'b0;
        idx   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            j = base + TW'(k);
            if (elig[j]) begin
                found = 1'b1;
                idx   = j;
            end
        end
    end

    // R5
    pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> elig[idx]);

    // R4
    pick_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> found);

endmodule

// File: rtl/rob_wake.sv
module rob_wake #(
    parameter int TW = 2,
    parameter int DW = 8
) (
    input  logic          p_in,
    input  logic [TW-1:0] t_in,
    input  logic [DW-1:0] v_in,
    input  logic          hit,
    input  logic [TW-1:0] hit_tag,
    input  logic [DW-1:0] hit_data,
    output logic          p_out,
    output logic [DW-1:0] v_out
);

    logic match;

    assign match = !p_in && hit && (hit_tag == t_in);
    assign p_out = p_in | match;
    assign v_out = match ? hit_data : v_in;

endmodule

// File: rtl/rob_data_buf.sv
module rob_data_buf
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH_DEF,
    parameter int DW    = ROB_DW_DEF,
    parameter int OPW   = ROB_OPW_DEF,
    parameter int AW    = ROB_AW_DEF,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           disp_valid,
    input  logic [OPW-1:0] disp_op,
    input  logic [AW-1:0]  disp_rd,
    input  logic           disp_s1_rdy,
    input  logic [TW-1:0]  disp_s1_tag,
    input  logic [DW-1:0]  disp_s1_val,
    input  logic           disp_s2_rdy,
    input  logic [TW-1:0]  disp_s2_tag,
    input  logic [DW-1:0]  disp_s2_val,
    output logic           disp_ready,
    output logic [TW-1:0]  disp_tag,
    input  logic           cmp_valid,
    input  logic [TW-1:0]  cmp_tag,
    input  logic [DW-1:0]  cmp_data,
    input  logic           cmp_exc,
    input  logic           iss_req,
    output logic           iss_valid,
    output logic [TW-1:0]  iss_tag,
    output logic [OPW-1:0] iss_op,
    output logic [DW-1:0]  iss_a,
    output logic [DW-1:0]  iss_b,
    output logic           cm_we,
    output logic [AW-1:0]  cm_rd,
    output logic [DW-1:0]  cm_data,
    output logic           trap
);

    typedef struct packed {
        logic           vld;
        logic           iss;
        logic [OPW-1:0] op;
        logic [AW-1:0]  rd;
        logic           p1;
        logic [TW-1:0]  t1;
        logic [DW-1:0]  v1;
        logic           p2;
        logic [TW-1:0]  t2;
        logic [DW-1:0]  v2;
        logic           done;
        logic [DW-1:0]  res;
        logic           exc;
    } ent_t;

    ent_t [DEPTH-1:0] ent_d, ent_q;

    logic [TW-1:0] head, tail;
    logic          full, empty;
    cm_act_e       cm_act;
    ent_t          head_ent;
    logic          disp_fire, cmp_hit, iss_fire;
    logic [DEPTH-1:0] elig;
    logic          pick_found;
    logic [TW-1:0] pick_idx;

    // Wakeup results for held sources and for the dispatch sources
    logic [DEPTH-1:0] w1p, w2p;
    logic [DW-1:0]    w1v [DEPTH];
    logic [DW-1:0]    w2v [DEPTH];
    logic             d1p, d2p;
    logic [DW-1:0]    d1v, d2v;

    rob_ptrs #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (disp_fire),
        .pop   (cm_act == CM_RETIRE),
        .flush (cm_act == CM_TRAP),
        .head  (head),
        .tail  (tail),
        .full  (full),
        .empty (empty)
    );

    // Head slot decides retirement or trap
    assign head_ent = ent_q[head];
    always_comb begin
        cm_act = CM_IDLE;
        if (head_ent.vld && head_ent.done)
            cm_act = head_ent.exc ? CM_TRAP : CM_RETIRE;
    end

    assign trap       = (cm_act == CM_TRAP);
    assign cm_we      = (cm_act == CM_RETIRE);
    assign cm_rd      = head_ent.rd;
    assign cm_data    = head_ent.res;
    assign disp_ready = !full && !trap;
    assign disp_tag   = tail;
    assign disp_fire  = disp_valid && disp_ready;
    assign cmp_hit    = cmp_valid && ent_q[cmp_tag].vld && !trap;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            assign elig[i] = ent_q[i].vld && !ent_q[i].iss && ent_q[i].p1 && ent_q[i].p2;

            rob_wake #(.TW(TW), .DW(DW)) u_w1 (
                .p_in (ent_q[i].p1), .t_in (ent_q[i].t1), .v_in (ent_q[i].v1),
                .hit  (cmp_hit), .hit_tag (cmp_tag), .hit_data (cmp_data),
                .p_out (w1p[i]), .v_out (w1v[i])
            );
            rob_wake #(.TW(TW), .DW(DW)) u_w2 (
                .p_in (ent_q[i].p2), .t_in (ent_q[i].t2), .v_in (ent_q[i].v2),
                .hit  (cmp_hit), .hit_tag (cmp_tag), .hit_data (cmp_data),
                .p_out (w2p[i]), .v_out (w2v[i])
            );
        end
    endgenerate

    // Same-cycle bypass for the incoming sources
    rob_wake #(.TW(TW), .DW(DW)) u_d1 (
        .p_in (disp_s1_rdy), .t_in (disp_s1_tag), .v_in (disp_s1_val),
        .hit  (cmp_hit), .hit_tag (cmp_tag), .hit_data (cmp_data),
        .p_out (d1p), .v_out (d1v)
    );
    rob_wake #(.TW(TW), .DW(DW)) u_d2 (
        .p_in (disp_s2_rdy), .t_in (disp_s2_tag), .v_in (disp_s2_val),
        .hit  (cmp_hit), .hit_tag (cmp_tag), .hit_data (cmp_data),
        .p_out (d2p), .v_out (d2v)
    );

    rob_pick #(.DEPTH(DEPTH), .TW(TW)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .base  (head),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign iss_valid = pick_found;
    assign iss_tag   = pick_idx;
    assign iss_op    = ent_q[pick_idx].op;
    assign iss_a     = ent_q[pick_idx].v1;
    assign iss_b     = ent_q[pick_idx].v2;
    assign iss_fire  = pick_found && iss_req && !trap;

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_q[i].vld) begin
                ent_d[i].p1 = w1p[i];
                ent_d[i].v1 = w1v[i];
                ent_d[i].p2 = w2p[i];
                ent_d[i].v2 = w2v[i];
            end
            if (cmp_hit && (cmp_tag == TW'(i))) begin
                ent_d[i].done = 1'b1;
                ent_d[i].res  = cmp_data;
                ent_d[i].exc  = cmp_exc;
            end
            if (iss_fire && (pick_idx == TW'(i)))
                ent_d[i].iss = 1'b1;
            if ((cm_act == CM_RETIRE) && (head == TW'(i)))
                ent_d[i].vld = 1'b0;
            if (disp_fire && (tail == TW'(i))) begin
                ent_d[i].vld  = 1'b1;
                ent_d[i].iss  = 1'b0;
                ent_d[i].op   = disp_op;
                ent_d[i].rd   = disp_rd;
                ent_d[i].p1   = d1p;
                ent_d[i].t1   = disp_s1_tag;
                ent_d[i].v1   = d1v;
                ent_d[i].p2   = d2p;
                ent_d[i].t2   = disp_s2_tag;
                ent_d[i].v2   = d2v;
                ent_d[i].done = 1'b0;
                ent_d[i].res  = '0;
                ent_d[i].exc  = 1'b0;
            end
            if (trap)
                ent_d[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    // R9
    trap_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (empty && !iss_valid && !cm_we));

    // R8
    retire_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |-> !empty);

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && !disp_s1_rdy && cmp_hit && (cmp_tag == disp_s1_tag))
        |=> ent_q[$past(tail)].p1);

    // R5
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && !disp_fire) |=> (!iss_valid || (iss_tag != $past(pick_idx))));

endmodule

// File: tb/tb_rob_data_buf.sv
module tb_rob_data_buf;

    localparam int D   = 4;
    localparam int DW  = 8;
    localparam int OPW = 4;
    localparam int AW  = 3;
    localparam int TW  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           disp_valid;
    logic [OPW-1:0] disp_op;
    logic [AW-1:0]  disp_rd;
    logic           disp_s1_rdy, disp_s2_rdy;
    logic [TW-1:0]  disp_s1_tag, disp_s2_tag;
    logic [DW-1:0]  disp_s1_val, disp_s2_val;
    logic           disp_ready;
    logic [TW-1:0]  disp_tag;
    logic           cmp_valid;
    logic [TW-1:0]  cmp_tag;
    logic [DW-1:0]  cmp_data;
    logic           cmp_exc;
    logic           iss_req;
    logic           iss_valid;
    logic [TW-1:0]  iss_tag;
    logic [OPW-1:0] iss_op;
    logic [DW-1:0]  iss_a, iss_b;
    logic           cm_we;
    logic [AW-1:0]  cm_rd;
    logic [DW-1:0]  cm_data;
    logic           trap;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rob_data_buf #(.DEPTH(D), .DW(DW), .OPW(OPW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_rd(disp_rd),
        .disp_s1_rdy(disp_s1_rdy), .disp_s1_tag(disp_s1_tag), .disp_s1_val(disp_s1_val),
        .disp_s2_rdy(disp_s2_rdy), .disp_s2_tag(disp_s2_tag), .disp_s2_val(disp_s2_val),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
        .iss_req(iss_req), .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op),
        .iss_a(iss_a), .iss_b(iss_b),
        .cm_we(cm_we), .cm_rd(cm_rd), .cm_data(cm_data), .trap(trap)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        disp_valid = 0; disp_op = 0; disp_rd = 0;
        disp_s1_rdy = 0; disp_s1_tag = 0; disp_s1_val = 0;
        disp_s2_rdy = 0; disp_s2_tag = 0; disp_s2_val = 0;
        cmp_valid = 0; cmp_tag = 0; cmp_data = 0; cmp_exc = 0;
        iss_req = 0;
    endtask

    // Advance to just after the next rising edge and drop all inputs
    task automatic cyc();
        @(posedge clk);
        #1;
        clr();
    endtask

    task automatic put(int op, int rd, bit r1, int t1, int v1, bit r2, int t2, int v2);
        disp_valid = 1; disp_op = OPW'(op); disp_rd = AW'(rd);
        disp_s1_rdy = r1; disp_s1_tag = TW'(t1); disp_s1_val = DW'(v1);
        disp_s2_rdy = r2; disp_s2_tag = TW'(t2); disp_s2_val = DW'(v2);
    endtask

    task automatic bcast(int tag, int data, bit exc);
        cmp_valid = 1; cmp_tag = TW'(tag); cmp_data = DW'(data); cmp_exc = exc;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int head_p;
        int tail_p;
        int h;
        clr();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        #4;
        // R1 reset state
        check("R1 disp_ready", disp_ready, 1);
        check("R1 disp_tag", disp_tag, 0);
        check("R1 iss_valid", iss_valid, 0);
        check("R1 cm_we", cm_we, 0);
        check("R1 trap", trap, 0);
        cyc();

        head_p = 0;
        tail_p = 0;
        for (int r = 0; r < 8; r++) begin
            int n = (r % 4) + 1;
            // Dispatch n ready instructions
            for (int k = 0; k < n; k++) begin
                put((r + k) & 15, k, 1, 0, r * 16 + k, 1, 0, k * 3 + 1);
                #4;
                check("R2 disp_ready", disp_ready, 1);
                check("R2 disp_tag", disp_tag, (tail_p + k) % D);
                cyc();
            end
            tail_p = tail_p + n;
            if (n == D) begin
                put(15, 7, 1, 0, 200, 1, 0, 200);
                #4;
                check("R3 full stall", disp_ready, 0);
                cyc();
            end
            // Issue in age order
            for (int k = 0; k < n; k++) begin
                iss_req = 1;
                #4;
                check("R5 iss_valid", iss_valid, 1);
                check("R5 oldest tag", iss_tag, (head_p + k) % D);
                check("R4 iss_op", iss_op, (r + k) & 15);
                check("R4 iss_a", iss_a, r * 16 + k);
                check("R4 iss_b", iss_b, k * 3 + 1);
                cyc();
            end
            #4;
            check("R5 no reissue", iss_valid, 0);
            // Complete youngest first
            for (int k = n - 1; k >= 0; k--) begin
                bcast((head_p + k) % D, r * 16 + k + k * 3 + 1, 0);
                #0;
                check("R8 head not done", cm_we, 0);
                cyc();
            end
            // Retire in order, one per cycle
            for (int k = 0; k < n; k++) begin
                #4;
                check("R8 cm_we", cm_we, 1);
                check("R8 cm_rd", cm_rd, k);
                check("R8 cm_data", cm_data, r * 16 + k + k * 3 + 1);
                cyc();
            end
            head_p = head_p + n;
            #4;
            check("R3 nothing left", cm_we, 0);
            check("R3 empty issue", iss_valid, 0);
            check("R2 tag after wrap", disp_tag, tail_p % D);
            cyc();
        end

        // Wakeup, bypass and trap sequence
        h = head_p % D;
        put(1, 1, 1, 0, 10, 1, 0, 20);        // A at h
        cyc();
        put(2, 2, 0, h, 0, 1, 0, 5);          // B at h+1 waits on A
        cyc();
        put(3, 3, 1, 0, 7, 0, (h + 1) % D, 0); // C at h+2 waits on B
        cyc();
        iss_req = 1;
        #4;
        check("R4 only ready issues", iss_tag, h);
        check("R4 iss_valid A", iss_valid, 1);
        cyc();
        bcast((h + 3) % D, 99, 0);           // no slot holds this tag
        #4;
        check("R4 waiting not offered", iss_valid, 0);
        cyc();
        #4;
        check("R10 stray completion", iss_valid, 0);
        bcast(h, 30, 0);
        cyc();
        iss_req = 1;
        #4;
        check("R8 A retires", cm_we, 1);
        check("R8 A data", cm_data, 30);
        check("R6 B woken", iss_valid, 1);
        check("R6 B tag", iss_tag, (h + 1) % D);
        check("R6 B operand", iss_a, 30);
        check("R6 B other", iss_b, 5);
        cyc();
        // Complete B while dispatching D that waits on B
        bcast((h + 1) % D, 35, 0);
        put(4, 4, 0, (h + 1) % D, 0, 1, 0, 1);
        #4;
        check("R7 D tag", disp_tag, (h + 3) % D);
        cyc();
        iss_req = 1;
        #4;
        check("R8 B retires", cm_we, 1);
        check("R8 B rd", cm_rd, 2);
        check("R6 C tag", iss_tag, (h + 2) % D);
        check("R6 C operand", iss_b, 35);
        cyc();
        iss_req = 1;
        #4;
        check("R7 D offered", iss_valid, 1);
        check("R7 D tag", iss_tag, (h + 3) % D);
        check("R7 D bypass", iss_a, 35);
        cyc();
        bcast((h + 3) % D, 36, 0);
        cyc();
        bcast((h + 2) % D, 0, 1);
        cyc();
        #4;
        check("R9 trap", trap, 1);
        check("R9 no write", cm_we, 0);
        check("R9 no dispatch", disp_ready, 0);
        cyc();
        #4;
        check("R9 trap pulse", trap, 0);
        check("R9 flushed retire", cm_we, 0);
        check("R9 flushed issue", iss_valid, 0);
        check("R9 free at oldest", disp_tag, (h + 2) % D);
        check("R9 ready", disp_ready, 1);
        put(5, 6, 1, 0, 40, 1, 0, 2);
        cyc();
        iss_req = 1;
        #4;
        check("R9 new issue", iss_tag, (h + 2) % D);
        cyc();
        bcast((h + 2) % D, 42, 0);
        cyc();
        #4;
        check("R9 new retire", cm_we, 1);
        check("R9 new rd", cm_rd, 6);
        check("R9 new data", cm_data, 42);
        cyc();

        finished = 1;
        summary();
        $finish;
    end

endmodule